// File: doc/BRIEF.md
# Scatter-Gather IDE Bus-Master DMA Engine

This block moves data for a single IDE channel between system memory and the drive's byte stream. Software writes the memory address of a descriptor list, the address of a small completion area and a direction flag into a word-indexed register file, then sets a start bit. The engine walks the list one 16-byte descriptor at a time. Each descriptor names a buffer of up to 64 KB. The engine moves that buffer one 32-bit word per beat through a single-request memory port and a pair of valid/ready device streams.

When the descriptor that carries the end-of-list flag has been consumed, the engine fills the completion area with all-ones words and raises a transfer interrupt. Software can poll that area or wait for the interrupt. Two free-running byte counters show how much has crossed the device side and how much has crossed the memory side. A stop request halts the engine at the next safe point. An error response from memory aborts the transfer and raises a second interrupt cause.

Top module: `sg_ide_dma`

## Requirements
- R1: After reset the control/status word (register index 7), both byte counters (indices 5 and 6), the interrupt output and the memory request all read zero.
- R2: A descriptor is fetched as four word reads at list address +0, +4, +8, +12. Each word is byte-swapped from big-endian. Word 1 gives the buffer address. Word 3 gives the byte length in bits 15:0 and the end-of-list flag in bit 31. Words 0 and 2 are ignored.
- R3: With direction bit 2 clear, memory words are read in increasing address order and presented on the outgoing device stream in that order, one word per beat, including a final partial word.
- R4: With direction bit 2 set, words taken from the incoming device stream are written to increasing memory addresses. A final beat of n<4 bytes writes with byte enables set for the low n lanes (1→0001, 2→0011, 3→0111); full beats use 1111.
- R5: A length field of zero moves 65536 bytes.
- R6: After a descriptor without end-of-list the next one is fetched 16 bytes further on. Nothing is fetched after a descriptor with end-of-list set.
- R7: On completion the engine writes END_WORDS all-ones words with full byte enables at the ending address (index 8) and upward. It then sets interrupt status bit 0, and active (control bit 3) reads 0.
- R8: The device-side counter (index 5) and the memory-side counter (index 6) are cleared at start. Both end equal to the bytes moved and never differ by more than 4.
- R9: Writing control bit 1 requests a stop. The bit reads 1 while the engine is still busy with an outstanding memory access, and reads 0 once the engine is idle. A stopped transfer performs no ending write and raises no interrupt.
- R10: A memory error response sets control bit 4 and interrupt status bit 1, clears active, and no further memory request follows. Writing 1 to control bit 4 clears the error flag.
- R11: A start write while active is ignored: counters are not cleared, no descriptor is refetched, and the transfer completes unchanged.
- R12: With address bit 4 set, index 3 reads the two interrupt status bits, index 5 sets bits written as 1 and index 7 clears bits written as 1. The irq output is high while any status bit is set.
- R13: Indices 0 (timing), 1 and 2 (list pointer low/high) and 8 (ending address) read back what was written. Index 3 shows the current buffer address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word index; bit 4 selects the interrupt registers |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_ack | input | 1 | Request accepted and completed |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| dev_out_valid | output | 1 | Outgoing device word valid |
| dev_out_ready | input | 1 | Device accepts outgoing word |
| dev_out_data | output | 32 | Outgoing device word |
| dev_in_valid | input | 1 | Incoming device word valid |
| dev_in_ready | output | 1 | Engine accepts incoming word |
| dev_in_data | input | 32 | Incoming device word |
| irq | output | 1 | Interrupt, OR of status bits |

## Verification
The bench builds the engine with END_WORDS set to 8, so each completion fill is short and the whole ending area can be checked word by word. The memory model adds a random 0–2 cycle latency per access, can hold requests indefinitely, and can return an error at one chosen address. Together these make it possible to see the stop bit still set during an outstanding access and to abort a transfer mid-list. The 65536-byte case from a zero length field runs with zero-latency memory and an always-ready device, which keeps that test within the cycle budget.

// File: rtl/sg_ide_dma.sv
module sg_ide_dma #(
  parameter int END_WORDS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  output logic        dev_out_valid,
  input  logic        dev_out_ready,
  output logic [31:0] dev_out_data,
  input  logic        dev_in_valid,
  output logic        dev_in_ready,
  input  logic [31:0] dev_in_data,
  output logic        irq
);
  localparam int EW = (END_WORDS > 1) ? $clog2(END_WORDS) : 1;
  localparam logic [EW-1:0] END_LAST = EW'(END_WORDS - 1);
  localparam logic [31:0] DESC_STEP = 32'd16;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RDMEM, S_PUSH, S_PULL, S_WRMEM, S_END} st_t;

  st_t         st, after_beat;
  logic [1:0]  widx, irq_st;
  logic [EW-1:0] end_cnt;
  logic [31:0] desc_ptr, cur_addr, data_q, bc_dev, bc_mem;
  logic [31:0] timing_q, lptr_lo, lptr_hi, end_base;
  logic [16:0] rem;
  logic        eol, dir, stop_q, err_q;

  wire [3:0]  idx      = reg_addr[3:0];
  wire        dma_wr   = reg_we && !reg_addr[4];
  wire        irq_wr   = reg_we && reg_addr[4];
  wire        ctrl_wr  = dma_wr && idx == 4'd7;
  wire        start_go = ctrl_wr && reg_wdata[0] && !reg_wdata[1] && st == S_IDLE;
  wire [31:0] swapped  = {mem_rdata[7:0], mem_rdata[15:8], mem_rdata[23:16], mem_rdata[31:24]};
  wire [2:0]  beat     = (rem >= 17'd4) ? 3'd4 : rem[2:0];
  wire [31:0] beat32   = {29'd0, beat};
  wire        last_beat = rem == {14'd0, beat};
  wire        acked    = mem_req && mem_ack;
  wire        err_evt  = acked && mem_err;
  wire        done_evt = st == S_END && acked && !mem_err && end_cnt == END_LAST;
  wire [3:0]  lane_be  = (beat == 3'd4) ? 4'hF : ((4'd1 << beat) - 4'd1);
  wire [1:0]  sw_set   = (irq_wr && idx == 4'd5) ? reg_wdata[1:0] : 2'b00;
  wire [1:0]  sw_clr   = (irq_wr && idx == 4'd7) ? reg_wdata[1:0] : 2'b00;

  always_comb begin
    if (!last_beat) after_beat = dir ? S_PULL : S_RDMEM;
    else if (eol)   after_beat = S_END;
    else            after_beat = S_FETCH;
  end

  assign mem_req = st == S_FETCH || st == S_RDMEM || st == S_WRMEM || st == S_END;
  assign mem_we  = st == S_WRMEM || st == S_END;
  assign mem_wdata = (st == S_END) ? '1 : data_q;
  assign mem_be    = (st == S_END) ? 4'hF : lane_be;
  assign dev_out_valid = st == S_PUSH;
  assign dev_out_data  = data_q;
  assign dev_in_ready  = st == S_PULL;
  assign irq = |irq_st;

  always_comb begin
    case (st)
      S_FETCH: mem_addr = desc_ptr + {28'd0, widx, 2'b00};
      S_END:   mem_addr = end_base + {{(30-EW){1'b0}}, end_cnt, 2'b00};
      default: mem_addr = cur_addr;
    endcase
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[4]) begin
      if (idx == 4'd3) reg_rdata = {30'd0, irq_st};
    end else begin
      case (idx)
        4'd0: reg_rdata = timing_q;
        4'd1: reg_rdata = lptr_lo;
        4'd2: reg_rdata = lptr_hi;
        4'd3: reg_rdata = cur_addr;
        4'd5: reg_rdata = bc_dev;
        4'd6: reg_rdata = bc_mem;
        4'd7: reg_rdata = {27'd0, err_q, st != S_IDLE, dir, stop_q, 1'b0};
        4'd8: reg_rdata = end_base;
        default: reg_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; widx <= '0; irq_st <= '0; end_cnt <= '0;
      desc_ptr <= '0; cur_addr <= '0; data_q <= '0; bc_dev <= '0; bc_mem <= '0;
      timing_q <= '0; lptr_lo <= '0; lptr_hi <= '0; end_base <= '0;
      rem <= '0; eol <= 1'b0; dir <= 1'b0; stop_q <= 1'b0; err_q <= 1'b0;
    end else begin
      irq_st <= ((irq_st | sw_set) & ~sw_clr) | {err_evt, done_evt};
      if (dma_wr) begin
        case (idx)
          4'd0: timing_q <= reg_wdata;
          4'd1: lptr_lo  <= reg_wdata;
          4'd2: lptr_hi  <= reg_wdata;
          4'd8: end_base <= reg_wdata;
          default: ;
        endcase
      end
      if (st == S_IDLE) stop_q <= 1'b0;
      if (ctrl_wr) begin
        if (reg_wdata[1]) stop_q <= 1'b1;
        if (reg_wdata[4]) err_q <= 1'b0;
        if (st == S_IDLE) dir <= reg_wdata[2];
      end
      if (err_evt) err_q <= 1'b1;

      case (st)
        S_IDLE: if (start_go) begin
          st <= S_FETCH; desc_ptr <= lptr_lo; widx <= '0;
          bc_dev <= '0; bc_mem <= '0;
        end
        S_FETCH: if (acked) begin
          if (mem_err) st <= S_IDLE;
          else begin
            widx <= widx + 2'd1;
            if (widx == 2'd1) cur_addr <= swapped;
            if (widx == 2'd3) begin
              rem <= (swapped[15:0] == 16'd0) ? 17'h10000 : {1'b0, swapped[15:0]};
              eol <= swapped[31];
              st  <= stop_q ? S_IDLE : (dir ? S_PULL : S_RDMEM);
            end else if (stop_q) st <= S_IDLE;
          end
        end
        S_RDMEM: if (acked) begin
          if (mem_err) st <= S_IDLE;
          else begin
            data_q <= mem_rdata;
            bc_mem <= bc_mem + beat32;
            st <= stop_q ? S_IDLE : S_PUSH;
          end
        end
        S_PUSH: begin
          if (stop_q) st <= S_IDLE;
          else if (dev_out_ready) begin
            bc_dev <= bc_dev + beat32;
            cur_addr <= cur_addr + beat32;
            rem <= rem - {14'd0, beat};
            st <= after_beat;
            end_cnt <= '0;
            if (last_beat && !eol) begin desc_ptr <= desc_ptr + DESC_STEP; widx <= '0; end
          end
        end
        S_PULL: begin
          if (stop_q) st <= S_IDLE;
          else if (dev_in_valid) begin
            data_q <= dev_in_data;
            bc_dev <= bc_dev + beat32;
            st <= S_WRMEM;
          end
        end
        S_WRMEM: if (acked) begin
          if (mem_err) st <= S_IDLE;
          else begin
            bc_mem <= bc_mem + beat32;
            cur_addr <= cur_addr + beat32;
            rem <= rem - {14'd0, beat};
            st <= stop_q ? S_IDLE : after_beat;
            end_cnt <= '0;
            if (last_beat && !eol) begin desc_ptr <= desc_ptr + DESC_STEP; widx <= '0; end
          end
        end
        S_END: if (acked) begin
          if (mem_err || done_evt || stop_q) st <= S_IDLE;
          else end_cnt <= end_cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: a pending memory request keeps its address until acknowledged
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R3: an offered device word stays put until taken, unless a stop is pending
  a_r3_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dev_out_valid && !dev_out_ready && !stop_q |=> dev_out_valid && $stable(dev_out_data));

  // R8: the two byte counters never drift more than one beat apart
  a_r8_count_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_dev - bc_mem <= 32'd4) || (bc_mem - bc_dev <= 32'd4));

  // R9: an idle engine drops a stop request one cycle later
  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q && !mem_req && !dev_out_valid && !dev_in_ready && !(ctrl_wr && reg_wdata[1]) |=> !stop_q);

  // R10: an error response ends all memory traffic
  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> !mem_req);

  // R7: the completion interrupt appears only once the engine is idle
  a_r7_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_st[0]) && !$past(irq_wr) |-> !mem_req);
endmodule

// File: tb/tb_sg_ide_dma.sv
module tb_sg_ide_dma;
  localparam int CLK_P = 10;
  localparam int EW_N  = 8;
  localparam logic [31:0] END_A = 32'h900;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [4:0] reg_addr = '0; logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we; logic [31:0] mem_addr, mem_wdata; logic [3:0] mem_be;
  logic mem_ack = 0, mem_err = 0; logic [31:0] mem_rdata = '0;
  logic dev_out_valid, dev_out_ready = 0; logic [31:0] dev_out_data;
  logic dev_in_valid = 0, dev_in_ready; logic [31:0] dev_in_data = '0;
  logic irq;

  sg_ide_dma #(.END_WORDS(EW_N)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0; bit finished = 0;
  bit mem_hold = 0, fast_mem = 0, rdy_all = 0;
  logic [31:0] err_addr = 32'hFFFF_FFF0;
  int wait_cnt = 0, desc_reads = 0, req_cnt = 0, wlog_n = 0;
  logic [31:0] desc_mem [0:63];
  logic [31:0] wlog_a [0:127]; logic [31:0] wlog_d [0:127]; logic [3:0] wlog_b [0:127];
  logic [31:0] seg_a [0:7]; int seg_l [0:7]; int nseg = 0;
  int si = 0, off = 0, mism = 0, out_words = 0, in_taken = 0, in_seen = 0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h3C3C, ~a[15:0] ^ a[31:16]};
  endfunction
  function automatic logic [31:0] bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
  function automatic logic [3:0] mask_of(input int n);
    return (n >= 4) ? 4'hF : 4'((1 << n) - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin mem_ack <= 0; mem_err <= 0; wait_cnt = 0; end
    else if (mem_ack) begin mem_ack <= 0; mem_err <= 0; end
    else if (mem_req && !mem_hold) begin
      if (wait_cnt > 0) wait_cnt--;
      else begin
        mem_ack <= 1; mem_err <= (mem_addr == err_addr); req_cnt++;
        if (mem_addr >= 32'h1000 && mem_addr < 32'h1100) begin
          mem_rdata <= desc_mem[mem_addr[7:2]];
          if (!mem_we) desc_reads++;
        end else mem_rdata <= pat(mem_addr);
        if (mem_we && wlog_n < 128) begin
          wlog_a[wlog_n] = mem_addr; wlog_d[wlog_n] = mem_wdata; wlog_b[wlog_n] = mem_be; wlog_n++;
        end
        wait_cnt = fast_mem ? 0 : $urandom_range(0, 2);
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n && dev_out_valid && dev_out_ready) begin
      if (si < nseg) begin
        if (dev_out_data !== pat(seg_a[si] + off)) mism++;
        off += 4;
        if (off >= seg_l[si]) begin si++; off = 0; end
      end else mism++;
      out_words++;
    end
    if (rst_n && dev_in_valid && dev_in_ready) in_taken++;
  end

  always @(negedge clk) begin
    dev_out_ready = rdy_all ? 1'b1 : ($urandom_range(0, 2) != 0);
    if (!dev_in_valid || in_taken != in_seen) begin
      dev_in_valid = ($urandom_range(0, 3) != 0);
      in_seen = in_taken;
    end
    dev_in_data = 32'hC0DE_0000 + 32'(in_taken);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask
  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask
  task automatic set_desc(input int slot, input logic [31:0] a, input logic [15:0] len, input bit e);
    desc_mem[slot*4+0] = '0; desc_mem[slot*4+1] = bswap(a);
    desc_mem[slot*4+2] = '0; desc_mem[slot*4+3] = bswap({e, 15'h7A5A & 15'h0, len});
  endtask
  task automatic add_seg(input logic [31:0] a, input logic [15:0] len, input bit e);
    set_desc(nseg, a, len, e);
    seg_a[nseg] = a; seg_l[nseg] = (len == 0) ? 65536 : int'(len); nseg++;
  endtask
  task automatic clear_track();
    nseg = 0; si = 0; off = 0; mism = 0; out_words = 0; wlog_n = 0; desc_reads = 0; in_taken = 0; in_seen = 0;
    for (int i = 0; i < 64; i++) desc_mem[i] = '0;
  endtask
  task automatic go(input bit d);
    wr(5'h01, 32'h1000); wr(5'h08, END_A);
    wr(5'h07, {29'd0, d, 2'b00}); wr(5'h07, {29'd0, d, 2'b01});
  endtask
  task automatic wait_irq();
    for (int k = 0; k < 120000 && !irq; k++) @(negedge clk);
    @(negedge clk);
  endtask
  function automatic int total_bytes();
    int t = 0;
    for (int s = 0; s < nseg; s++) t += seg_l[s];
    return t;
  endfunction
  function automatic int total_words();
    int t = 0;
    for (int s = 0; s < nseg; s++) t += (seg_l[s] + 3) / 4;
    return t;
  endfunction
  task automatic chk_end(input string tag, input int k0);
    int e = 0;
    for (int j = 0; j < EW_N; j++)
      if (wlog_a[k0+j] !== END_A + 32'(4*j) || wlog_d[k0+j] !== 32'hFFFF_FFFF || wlog_b[k0+j] !== 4'hF) e++;
    chk({tag, " ending-area words"}, 32'(e), 0);
    chk({tag, " write count"}, 32'(wlog_n), 32'(k0 + EW_N));
  endtask
  task automatic chk_wlog(input string tag);
    int k = 0, e = 0;
    for (int s = 0; s < nseg; s++)
      for (int o = 0; o < seg_l[s]; o += 4) begin
        if (wlog_a[k] !== seg_a[s] + 32'(o) || wlog_d[k] !== 32'hC0DE_0000 + 32'(k) ||
            wlog_b[k] !== mask_of(seg_l[s] - o)) e++;
        k++;
      end
    chk({tag, " R4 memory writes"}, 32'(e), 0);
    chk_end({tag, " R7"}, k);
  endtask

  initial begin
    logic [31:0] v;
    int rq;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(5'h07, v); chk("R1 ctrl after reset", v, 0);
    rd(5'h05, v); chk("R1 device counter after reset", v, 0);
    rd(5'h06, v); chk("R1 memory counter after reset", v, 0);
    chk("R1 irq and request after reset", {30'd0, irq, mem_req}, 0);

    // R13 register map
    wr(5'h00, 32'h1234_5678); wr(5'h02, 32'h0000_ABCD); wr(5'h08, 32'h0000_0F00);
    rd(5'h00, v); chk("R13 timing readback", v, 32'h1234_5678);
    rd(5'h02, v); chk("R13 list high readback", v, 32'h0000_ABCD);
    rd(5'h08, v); chk("R13 ending address readback", v, 32'h0000_0F00);

    // R12 interrupt set/clear
    wr(5'h15, 32'h3); rd(5'h13, v); chk("R12 set both", {v[31:2], v[1:0]}, 3);
    chk("R12 irq high", {31'd0, irq}, 1);
    wr(5'h17, 32'h1); rd(5'h13, v); chk("R12 clear bit0", v, 2);
    wr(5'h17, 32'h2); rd(5'h13, v); chk("R12 clear bit1", v, 0);
    chk("R12 irq low", {31'd0, irq}, 0);

    // R2 R3 R6 R7 R8 directed to-device with partial beat and decoy descriptor
    clear_track();
    add_seg(32'h8000, 16'd8, 0); add_seg(32'h8100, 16'd13, 0); add_seg(32'h8200, 16'd4, 1);
    set_desc(3, 32'h8300, 16'd4, 1);
    go(0); wait_irq();
    chk("R2 R6 descriptor reads", 32'(desc_reads), 12);
    chk("R3 stream mismatches", 32'(mism), 0);
    chk("R3 stream words", 32'(out_words), 7);
    rd(5'h05, v); chk("R8 device bytes", v, 25);
    rd(5'h06, v); chk("R8 memory bytes", v, 25);
    rd(5'h03, v); chk("R13 current address", v, 32'h8204);
    chk_end("R7 to-device", 0);
    rd(5'h13, v); chk("R7 done status", v, 1);
    rd(5'h07, v); chk("R7 active clear", {28'd0, v[3:0]}, 0);
    wr(5'h17, 3);

    // R4 directed to-memory
    clear_track();
    add_seg(32'h8400, 16'd6, 0); add_seg(32'h8500, 16'd8, 1);
    go(1); wait_irq();
    chk_wlog("directed");
    rd(5'h05, v); chk("R8 to-memory device bytes", v, 14);
    rd(5'h06, v); chk("R8 to-memory memory bytes", v, 14);
    wr(5'h17, 3);

    // R11 start while active
    clear_track();
    add_seg(32'h8000, 16'd64, 1);
    go(0); repeat (6) @(negedge clk); wr(5'h07, 32'h1);
    wait_irq();
    rd(5'h05, v); chk("R11 counter not cleared", v, 64);
    chk("R11 no refetch", 32'(desc_reads), 4);
    chk("R11 stream intact", {16'(out_words), 16'(mism)}, {16'd16, 16'd0});
    wr(5'h17, 3);

    // R9 stop during an outstanding read
    clear_track();
    add_seg(32'h8000, 16'h0400, 1);
    rdy_all = 1;
    go(0); repeat (12) @(negedge clk);
    mem_hold = 1; repeat (5) @(negedge clk);
    wr(5'h07, 32'h2);
    rd(5'h07, v); chk("R9 stop and active held", {28'd0, v[3:0]} & 32'hA, 32'hA);
    mem_hold = 0; repeat (10) @(negedge clk);
    rd(5'h07, v); chk("R9 stop and active cleared", {28'd0, v[3:0]} & 32'hA, 0);
    chk("R9 no ending write or irq", {wlog_n[30:0], irq}, 0);
    rdy_all = 0;

    // R10 error response
    clear_track();
    add_seg(32'h8000, 16'd32, 1);
    err_addr = 32'h8008;
    go(0); wait_irq();
    rd(5'h07, v); chk("R10 error set active clear", v & 32'h18, 32'h10);
    rd(5'h13, v); chk("R10 error status", v, 2);
    rd(5'h06, v); chk("R10 memory bytes before error", v, 8);
    rq = req_cnt; repeat (10) @(negedge clk);
    chk("R10 no further requests", 32'(req_cnt - rq), 0);
    chk("R10 no ending write", 32'(wlog_n), 0);
    wr(5'h07, 32'h10); rd(5'h07, v); chk("R10 error cleared", v & 32'h10, 0);
    wr(5'h17, 3); err_addr = 32'hFFFF_FFF0;

    // random transfers
    for (int it = 0; it < 4; it++) begin
      bit d = 1'($urandom_range(0, 1));
      int ns = $urandom_range(1, 3);
      clear_track();
      for (int s = 0; s < ns; s++)
        add_seg(32'h8000 + 32'(s) * 32'h100, 16'($urandom_range(1, 40)), s == ns - 1);
      go(d); wait_irq();
      rd(5'h05, v); chk("R8 random device bytes", v, 32'(total_bytes()));
      rd(5'h06, v); chk("R8 random memory bytes", v, 32'(total_bytes()));
      if (d) chk_wlog("random");
      else begin
        chk("R3 random stream", {16'(out_words), 16'(mism)}, {16'(total_words()), 16'd0});
        chk_end("R7 random", 0);
      end
      chk("R6 random descriptor reads", 32'(desc_reads), 32'(4 * ns));
      wr(5'h17, 3);
    end

    // R5 zero length field
    clear_track();
    add_seg(32'h0002_0000, 16'd0, 1);
    fast_mem = 1; rdy_all = 1;
    go(0); wait_irq();
    rd(5'h05, v); chk("R5 device bytes", v, 32'h10000);
    rd(5'h06, v); chk("R5 memory bytes", v, 32'h10000);
    chk("R5 stream", {16'(out_words), 16'(mism)}, {16'(16384), 16'd0});

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule